// File: doc/BRIEF.md
# Bandwidth-Adaptive Spatial Pattern Prefetcher

This block observes demand accesses, keeps a small table of recently touched physical pages, and for each tracked page records which cache lines have been used. The record is a bit-pattern in which bit 0 stands for the first access seen in the page (the trigger), and every other bit counts line distance from that trigger, wrapping within the page. When a tracked page is displaced, its record is folded into a pattern table indexed by a signature hashed from the trigger's program counter. Each pattern entry holds two learned patterns: a wide one grown by union (coverage) and a narrow one shrunk by intersection (accuracy).

On every new trigger the block looks up the trigger's signature. If a learned entry exists, a 2-bit DRAM bandwidth-utilization code picks one of the two patterns. Light and moderate load choose the wide pattern, and near-peak load chooses the narrow one. The chosen bits are turned back into absolute line addresses in the trigger's page and issued one per cycle on a valid/ready output.

Top module: `spatial_bw_prefetch`

## Requirements
- R1: After reset, no tracking entry and no pattern entry is valid, and `pfValid` is low.
- R2: An access whose page matches no valid tracking entry is a trigger. A trigger takes the lowest-numbered free tracking slot. If no slot is free, it takes the slot named by a round-robin pointer that starts at 0 and advances by one on each such displacement. The trigger's signature is the XOR of the consecutive `log2(PAT_N)`-bit slices of `accPc`, starting at bit 0.
- R3: A tracked page's pattern starts as bit 0 alone. Each later access to that page sets bit `(line offset - trigger offset) mod LINES`, where the line offset is the low `PAGE_BITS-LINE_BITS` bits of the line address.
- R4: When a valid tracking entry is displaced and its signature has no valid pattern entry, both stored patterns become a copy of its record. Otherwise the coverage pattern becomes the OR of the stored pattern and the record, and the accuracy pattern becomes the AND. A trigger's lookup sees the table as it was before a merge made in the same cycle.
- R5: For a trigger with a valid pattern entry, bandwidth code 3 selects the accuracy pattern, and codes 0, 1 and 2 select the coverage pattern.
- R6: A trigger whose signature has no valid pattern entry issues no prefetch.
- R7: Prefetches come out one per accepted cycle, in ascending order of pattern bit index. Each one is the trigger's page with line offset `(trigger offset + index) mod LINES`. Bit 0, the trigger line, is never issued.
- R8: While `pfValid` is high and `pfReady` is low, `pfValid` and `pfLine` hold unless a new burst is loaded.
- R9: A trigger with a valid pattern entry discards any unfinished burst and replaces it with its own. If its selected pattern has no bit other than bit 0, nothing further is issued.
- R10: An access to a page that is already tracked starts no prefetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| accValid | input | 1 | Demand access strobe |
| accLine | input | ADDR_W-LINE_BITS | Line address of the access (page number above, line offset below) |
| accPc | input | PC_W | Program counter of the access |
| bwLevel | input | 2 | DRAM bandwidth-utilization quartile, 3 = near peak |
| pfValid | output | 1 | Prefetch request present |
| pfReady | input | 1 | Downstream accepts the prefetch this cycle |
| pfLine | output | ADDR_W-LINE_BITS | Line address to prefetch |

## Verification
The bench builds the block with four tracking slots and sixteen pattern entries, and keeps the 64-line page. With only four slots, a few triggers are enough to force displacement, exercise the round-robin victim order, and run the union and intersection merges several times on one signature. As a result, coverage and accuracy patterns diverge in a short directed sequence. A trigger at line 63 makes the de-rotation wrap, and a second trigger sent during a stalled burst shows the replacement rule.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  // Strobes the control issues to the datapath for one access cycle.
  typedef struct packed {
    logic recordHit;  // set a bit in the matching tracking entry
    logic allocate;   // write the trigger into the chosen slot
    logic mergeOld;   // fold the displaced entry into the pattern table
    logic loadBurst;  // replace the pending burst with a learned pattern
    logic selAcc;     // pick the accuracy pattern for the burst
  } ctrlStrobe_t;

endpackage

// File: rtl/sbp_control.sv
module sbp_control
  import sbp_pkg::*;
#(
  parameter int TRACK_N = 16,
  localparam int SLOT_W = $clog2(TRACK_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [1:0]        bwLevel,
  input  logic [TRACK_N-1:0] hitVec,
  input  logic [TRACK_N-1:0] trkValidVec,
  input  logic              patHit,
  output ctrlStrobe_t       strobe,
  output logic [SLOT_W-1:0] slot
);

  logic [SLOT_W-1:0] rrPtr;
  logic [SLOT_W-1:0] freeIdx;
  logic              freeAny;
  logic              isTrigger;

  // Lowest-numbered free slot, found by scanning downward.
  always_comb begin
    freeAny = 1'b0;
    freeIdx = '0;
    for (int i = TRACK_N - 1; i >= 0; i--) begin
      if (!trkValidVec[i]) begin
        freeAny = 1'b1;
        freeIdx = SLOT_W'(i);
      end
    end
  end

  assign isTrigger = accValid && (hitVec == '0);
  assign slot      = freeAny ? freeIdx : rrPtr;

  always_comb begin
    strobe           = '0;
    strobe.recordHit = accValid && (hitVec != '0);
    strobe.allocate  = isTrigger;
    strobe.mergeOld  = isTrigger && !freeAny;
    strobe.loadBurst = isTrigger && patHit;
    strobe.selAcc    = (bwLevel == 2'd3);
  end

  // The round-robin pointer moves only when a live entry is displaced.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.mergeOld) begin
      rrPtr <= (rrPtr == SLOT_W'(TRACK_N - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

endmodule

// File: rtl/sbp_datapath.sv
module sbp_datapath
  import sbp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PC_W      = 32,
  parameter int LINE_BITS = 6,
  parameter int PAGE_BITS = 12,
  parameter int TRACK_N   = 16,
  parameter int PAT_N     = 64,
  localparam int LADDR_W  = ADDR_W - LINE_BITS,
  localparam int OFF_W    = PAGE_BITS - LINE_BITS,
  localparam int PAGE_W   = ADDR_W - PAGE_BITS,
  localparam int LINES    = 1 << OFF_W,
  localparam int SIG_W    = $clog2(PAT_N),
  localparam int SLOT_W   = $clog2(TRACK_N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LADDR_W-1:0] accLine,
  input  logic [PC_W-1:0]    accPc,
  input  ctrlStrobe_t        strobe,
  input  logic [SLOT_W-1:0]  slot,
  output logic [TRACK_N-1:0] hitVec,
  output logic [TRACK_N-1:0] trkValidVec,
  output logic               patHit,
  output logic               pfValid,
  input  logic               pfReady,
  output logic [LADDR_W-1:0] pfLine,
  output logic [OFF_W-1:0]   pendTrig
);

  // Page tracking table
  logic [TRACK_N-1:0]             trkValid;
  logic [TRACK_N-1:0][PAGE_W-1:0] trkPage;
  logic [TRACK_N-1:0][OFF_W-1:0]  trkTrig;
  logic [TRACK_N-1:0][SIG_W-1:0]  trkSig;
  logic [TRACK_N-1:0][LINES-1:0]  trkPat;

  // Learned pattern table
  logic [PAT_N-1:0]            patValid;
  logic [PAT_N-1:0][LINES-1:0] covPat;
  logic [PAT_N-1:0][LINES-1:0] accPat;

  // Pending burst
  logic [LINES-1:0]  pendMask;
  logic [PAGE_W-1:0] pendPage;

  logic [PAGE_W-1:0] accPage;
  logic [OFF_W-1:0]  accOff;
  logic [SIG_W-1:0]  accSig;
  logic [TRACK_N-1:0][OFF_W-1:0] rotIdx;
  logic [SIG_W-1:0]  victimSig;
  logic [LINES-1:0]  victimPat;
  logic [LINES-1:0]  pickPat;
  logic [OFF_W-1:0]  curIdx;
  logic [OFF_W-1:0]  outOff;

  assign accPage = accLine[LADDR_W-1:OFF_W];
  assign accOff  = accLine[OFF_W-1:0];

  // Signature: fold every PC bit into SIG_W bits by XOR.
  always_comb begin
    accSig = '0;
    for (int i = 0; i < PC_W; i++) begin
      accSig[i % SIG_W] = accSig[i % SIG_W] ^ accPc[i];
    end
  end

  // Per-entry match and rotated line index
  always_comb begin
    for (int i = 0; i < TRACK_N; i++) begin
      hitVec[i] = trkValid[i] && (trkPage[i] == accPage);
      rotIdx[i] = accOff - trkTrig[i];
    end
  end

  assign trkValidVec = trkValid;
  assign patHit      = patValid[accSig];
  assign victimSig   = trkSig[slot];
  assign victimPat   = trkPat[slot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trkValid <= '0;
    end else if (strobe.allocate) begin
      trkValid[slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.recordHit) begin
      for (int i = 0; i < TRACK_N; i++) begin
        if (hitVec[i]) begin
          trkPat[i][rotIdx[i]] <= 1'b1;
        end
      end
    end
    if (strobe.allocate) begin
      trkPage[slot] <= accPage;
      trkTrig[slot] <= accOff;
      trkSig[slot]  <= accSig;
      trkPat[slot]  <= LINES'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patValid <= '0;
    end else if (strobe.mergeOld) begin
      patValid[victimSig] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.mergeOld) begin
      if (!patValid[victimSig]) begin
        covPat[victimSig] <= victimPat;
        accPat[victimSig] <= victimPat;
      end else begin
        covPat[victimSig] <= covPat[victimSig] | victimPat;
        accPat[victimSig] <= accPat[victimSig] & victimPat;
      end
    end
  end

  // Burst load reads the table before this cycle's merge lands.
  assign pickPat = strobe.selAcc ? accPat[accSig] : covPat[accSig];

  always_comb begin
    curIdx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pendMask[i]) curIdx = OFF_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= '0;
    end else if (strobe.loadBurst) begin
      pendMask <= pickPat & ~LINES'(1);
    end else if (pfValid && pfReady) begin
      pendMask[curIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.loadBurst) begin
      pendPage <= accPage;
      pendTrig <= accOff;
    end
  end

  assign outOff  = pendTrig + curIdx;
  assign pfValid = (pendMask != '0);
  assign pfLine  = {pendPage, outOff};

endmodule

// File: rtl/spatial_bw_prefetch.sv
module spatial_bw_prefetch
  import sbp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PC_W      = 32,
  parameter int LINE_BITS = 6,
  parameter int PAGE_BITS = 12,
  parameter int TRACK_N   = 16,
  parameter int PAT_N     = 64,
  localparam int LADDR_W  = ADDR_W - LINE_BITS,
  localparam int OFF_W    = PAGE_BITS - LINE_BITS,
  localparam int SLOT_W   = $clog2(TRACK_N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic [LADDR_W-1:0] accLine,
  input  logic [PC_W-1:0]    accPc,
  input  logic [1:0]         bwLevel,
  output logic               pfValid,
  input  logic               pfReady,
  output logic [LADDR_W-1:0] pfLine
);

  ctrlStrobe_t        strobe;
  logic [SLOT_W-1:0]  slot;
  logic [TRACK_N-1:0] hitVec;
  logic [TRACK_N-1:0] trkValidVec;
  logic               patHit;
  logic [OFF_W-1:0]   pendTrig;

  sbp_control #(
    .TRACK_N(TRACK_N)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .bwLevel    (bwLevel),
    .hitVec     (hitVec),
    .trkValidVec(trkValidVec),
    .patHit     (patHit),
    .strobe     (strobe),
    .slot       (slot)
  );

  sbp_datapath #(
    .ADDR_W   (ADDR_W),
    .PC_W     (PC_W),
    .LINE_BITS(LINE_BITS),
    .PAGE_BITS(PAGE_BITS),
    .TRACK_N  (TRACK_N),
    .PAT_N    (PAT_N)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .accLine    (accLine),
    .accPc      (accPc),
    .strobe     (strobe),
    .slot       (slot),
    .hitVec     (hitVec),
    .trkValidVec(trkValidVec),
    .patHit     (patHit),
    .pfValid    (pfValid),
    .pfReady    (pfReady),
    .pfLine     (pfLine),
    .pendTrig   (pendTrig)
  );

endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  parameter int PAGE_BITS = 12,
  parameter int TRACK_N   = 16,
  localparam int LADDR_W  = ADDR_W - LINE_BITS,
  localparam int OFF_W    = PAGE_BITS - LINE_BITS
) (
  input logic               clk,
  input logic               rstN,
  input logic               pfValid,
  input logic               pfReady,
  input logic [LADDR_W-1:0] pfLine,
  input logic               loadBurst,
  input logic [TRACK_N-1:0] hitVec,
  input logic [OFF_W-1:0]   pendTrig
);

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !pfValid);

  p_single_owner_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  p_skip_trigger_line_r7: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> (pfLine[OFF_W-1:0] != pendTrig));

  p_hold_while_stalled_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfReady && !loadBurst) |=> (pfValid && $stable(pfLine)));

  p_only_from_burst_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!pfValid && !loadBurst) |=> !pfValid);

endmodule

bind spatial_bw_prefetch sbp_checker #(
  .ADDR_W   (ADDR_W),
  .LINE_BITS(LINE_BITS),
  .PAGE_BITS(PAGE_BITS),
  .TRACK_N  (TRACK_N)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pfValid  (pfValid),
  .pfReady  (pfReady),
  .pfLine   (pfLine),
  .loadBurst(strobe.loadBurst),
  .hitVec   (hitVec),
  .pendTrig (pendTrig)
);

// File: tb/tb_spatial_bw_prefetch.sv
`timescale 1ns/1ps
module tb_spatial_bw_prefetch;

  localparam int LADDR_W = 26;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               accValid = 1'b0;
  logic [LADDR_W-1:0] accLine = '0;
  logic [31:0]        accPc = '0;
  logic [1:0]         bwLevel = 2'd0;
  logic               pfValid;
  logic               pfReady = 1'b1;
  logic [LADDR_W-1:0] pfLine;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spatial_bw_prefetch #(
    .TRACK_N(4),
    .PAT_N  (16)
  ) dut (
    .clk     (clk),
    .rstN    (rstN),
    .accValid(accValid),
    .accLine (accLine),
    .accPc   (accPc),
    .bwLevel (bwLevel),
    .pfValid (pfValid),
    .pfReady (pfReady),
    .pfLine  (pfLine)
  );

  function automatic logic [LADDR_W-1:0] mkLine(int page, int off);
    return LADDR_W'((page << 6) | (off & 63));
  endfunction

  task automatic check(bit ok, string req, logic [LADDR_W-1:0] act, logic [LADDR_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic doAccess(int page, int off, int sig, int bw);
    accValid = 1'b1;
    accLine  = mkLine(page, off);
    accPc    = 32'(sig);
    bwLevel  = 2'(bw);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic expectBurst(string req, int page, int n, int o0, int o1, int o2);
    int offs[3];
    int got = 0;
    offs[0] = o0; offs[1] = o1; offs[2] = o2;
    pfReady = 1'b1;
    for (int c = 0; c < 12; c++) begin
      if (pfValid) begin
        if (got < n)
          check(pfLine == mkLine(page, offs[got]), req, pfLine, mkLine(page, offs[got]));
        else
          check(1'b0, {req, " extra prefetch"}, pfLine, '0);
        got++;
      end
      @(negedge clk);
    end
    check(got == n, {req, " count"}, LADDR_W'(got), LADDR_W'(n));
  endtask

  task automatic testReset();
    check(pfValid == 1'b0, "R1 idle after reset", LADDR_W'(pfValid), '0);
  endtask

  task automatic testColdAndFill();
    doAccess('h10, 5, 1, 0);                 // R2 trigger, sig 1 unknown
    doAccess('h10, 7, 1, 0);                 // R3 rotated index 2
    doAccess('h10, 3, 1, 0);                 // R3 rotated index 62
    expectBurst("R6 cold trigger", 'h10, 0, 0, 0, 0);
    doAccess('h11, 0, 2, 0);
    doAccess('h12, 0, 2, 0);
    doAccess('h13, 0, 2, 0);
    doAccess('h14, 0, 3, 0);                 // R2 displaces slot 0, R4 fresh copy
    expectBurst("R6 unknown sig", 'h14, 0, 0, 0, 0);
  endtask

  task automatic testCoverage();
    doAccess('h20, 10, 1, 0);                // R5 code 0 -> coverage
    expectBurst("R3 R7 coverage burst", 'h20, 2, 12, 8, 0);
  endtask

  task automatic testDiverge();
    doAccess('h20, 11, 1, 0);
    doAccess('h20, 12, 1, 0);
    expectBurst("R10 tracked page", 'h20, 0, 0, 0, 0);
    doAccess('h30, 0, 5, 0);
    doAccess('h31, 0, 5, 0);
    doAccess('h32, 0, 5, 0);
    doAccess('h33, 0, 5, 0);                 // R4 sig 1: cov {0,1,2,62}, acc {0,2}
    expectBurst("R6 sig 5 untrained", 'h33, 0, 0, 0, 0);
  endtask

  task automatic testAccuracyWrap();
    doAccess('h40, 63, 1, 3);                // R5 code 3 -> accuracy
    expectBurst("R4 R5 R7 accuracy wrap", 'h40, 1, 1, 0, 0);
  endtask

  task automatic testStall();
    pfReady = 1'b0;
    doAccess('h41, 0, 1, 2);                 // R5 code 2 -> coverage
    for (int c = 0; c < 3; c++) begin
      check(pfValid && pfLine == mkLine('h41, 1), "R8 hold under stall", pfLine, mkLine('h41, 1));
      @(negedge clk);
    end
    expectBurst("R8 drain after stall", 'h41, 3, 1, 2, 62);
  endtask

  task automatic testEmptyAccuracy();
    doAccess('h42, 0, 5, 3);                 // sig 5 learned only bit 0
    expectBurst("R9 empty accuracy", 'h42, 0, 0, 0, 0);
  endtask

  task automatic testReplace();
    pfReady = 1'b0;
    doAccess('h43, 0, 1, 0);
    check(pfValid && pfLine == mkLine('h43, 1), "R9 first burst head", pfLine, mkLine('h43, 1));
    doAccess('h44, 4, 1, 0);
    check(pfValid && pfLine == mkLine('h44, 5), "R9 replaced burst head", pfLine, mkLine('h44, 5));
    expectBurst("R9 replaced burst", 'h44, 3, 5, 6, 2);
  endtask

  task automatic testShrunkAccuracy();
    doAccess('h45, 0, 1, 3);                 // R4 AND left sig 1 accuracy at bit 0
    expectBurst("R4 shrunk accuracy", 'h45, 0, 0, 0, 0);
    doAccess('h44, 20, 1, 0);                // page tracked
    expectBurst("R10 hit no prefetch", 'h44, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testColdAndFill();
    testCoverage();
    testDiverge();
    testAccuracyWrap();
    testStall();
    testEmptyAccuracy();
    testReplace();
    testShrunkAccuracy();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule